// File: doc/BRIEF.md
# Credit-Reporting Write Buffer Target

This block is a bus target that takes 32-bit word writes into a small message FIFO. Each acknowledgement carries the number of FIFO words still free. A host that moves data, such as a DMA engine, can then send only as many words as the target can take. It can move on to other work instead of stalling the fabric on a full buffer.

A partial put with an all-zero byte mask is treated as a pure query. It stores nothing, and its acknowledgement still reports the free-word count. A host can therefore learn the available space before its first real write. A downstream consumer drains the FIFO through a pop port that takes one word per cycle while its enable input is high.

The credit value is only a hint. A host that ignores it sees ordinary ready/valid behaviour: when the buffer is full, the request is stalled.

Top module: `credit_wbuf`

## Requirements
- R1: After reset the FIFO is empty (`cons_valid` low), no response is pending (`rsp_valid` low), and `req_ready` is high.
- R2: An accepted request with opcode 0 (full put), or opcode 1 (partial put) with a non-zero `req_mask`, appends `req_data` to the FIFO. It is answered with response opcode 0 (acknowledge without data).
- R3: An accepted opcode 1 request whose `req_mask` is 4'b0000 stores nothing. It is still answered with response opcode 0 and a credit value.
- R4: `rsp_credit` equals DEPTH (16) minus the FIFO occupancy after the acceptance cycle's push and pop are both applied. A write into the last free slot, with no pop in that cycle, therefore reports 0.
- R5: An accepted request with any other opcode (for example 4, get) stores nothing. It is answered with response opcode 1 (acknowledge with data), `rsp_data` equal to zero, and the credit value.
- R6: While the FIFO holds DEPTH words, `req_ready` is low.
- R7: At most one response is outstanding. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response fields hold steady.
- R8: `cons_valid` is high exactly when the FIFO is not empty, and `cons_data` shows the oldest word. On each clock edge where `cons_en` and `cons_valid` are both high, one word is removed, in the order the words were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_opcode | input | 3 | 0 full put, 1 partial put, others read |
| req_mask | input | 4 | Byte mask; zero on a partial put means query |
| req_data | input | 32 | Write word |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_opcode | output | 3 | 0 acknowledge, 1 acknowledge with data |
| rsp_credit | output | 5 | Free FIFO words after the request |
| rsp_data | output | 32 | Read data, always zero |
| cons_en | input | 1 | Consumer pop enable |
| cons_valid | output | 1 | FIFO holds a word |
| cons_data | output | 32 | Oldest FIFO word |

## Verification
Directed phases come first. Back-to-back full puts show that each write lowers the credit. A zero-mask query is then followed by a masked partial put, which separates a query from a store. A get shows the data-acknowledge path.

Filling past capacity shows the zero credit on the last slot and then the stall. Holding `rsp_ready` low with requests pending exposes any second response that slips through.

A long mixed run with random opcodes, masks, consumer enable and response back-pressure then drives pushes and pops in the same cycle. This tests whether the credit is taken after both have been applied.

// File: rtl/credit_wbuf_pkg.sv
// Shared opcode encodings for the credit-reporting write buffer.
package credit_wbuf_pkg;
    localparam logic [2:0] REQ_PUT_FULL = 3'd0;
    localparam logic [2:0] REQ_PUT_PART = 3'd1;

    typedef enum logic [2:0] {
        RSP_ACK      = 3'd0,
        RSP_ACK_DATA = 3'd1
    } rsp_op_e;
endpackage

// File: rtl/wbuf_fifo.sv
// Word FIFO with an occupancy output.
// Assumes the caller never pushes when full and never pops when empty.
module wbuf_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  occ,
    output logic              full,
    output logic              empty
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      occ <= occ + 1'b1;
            else if (pop && !push) occ <= occ - 1'b1;
        end
    end

    assign rdata = mem[rd_ptr];
    assign full  = (occ == CNT_W'(DEPTH));
    assign empty = (occ == '0);
endmodule

// File: rtl/wbuf_rsp_slot.sv
// Single-entry response holding register.
// A load takes priority; an unloaded cycle with drain empties the slot.
module wbuf_rsp_slot
    import credit_wbuf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  rsp_op_e          ld_op,
    input  logic [CNT_W-1:0] ld_credit,
    input  logic             drain,
    output logic             valid,
    output rsp_op_e          op,
    output logic [CNT_W-1:0] credit,
    output logic             slot_free
);
    // Hold or replace the pending response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            op     <= RSP_ACK;
            credit <= '0;
        end else if (load) begin
            valid  <= 1'b1;
            op     <= ld_op;
            credit <= ld_credit;
        end else if (drain) begin
            valid  <= 1'b0;
        end
    end

    assign slot_free = !valid || drain;
endmodule

// File: rtl/credit_wbuf.sv
// Credit-reporting write-buffer target.
// Decodes requests, pushes data words, and returns the post-update free
// count on every response. Assumes one host drives the request channel.
module credit_wbuf
    import credit_wbuf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int MASK_W = DATA_W / 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_opcode,
    input  logic [MASK_W-1:0] req_mask,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_opcode,
    output logic [CNT_W-1:0]  rsp_credit,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              cons_en,
    output logic              cons_valid,
    output logic [DATA_W-1:0] cons_data
);
    logic             accept, is_put, push, pop, full, empty, slot_free;
    logic [CNT_W-1:0] occ, occ_next, credit_next;
    rsp_op_e          op_next, op_q;

    // Request decode and credit computation.
    always_comb begin
        req_ready   = slot_free && !full;
        accept      = req_valid && req_ready;
        is_put      = (req_opcode == REQ_PUT_FULL) || (req_opcode == REQ_PUT_PART);
        push        = accept && is_put &&
                      ((req_opcode == REQ_PUT_FULL) || (req_mask != '0));
        pop         = cons_en && !empty;
        occ_next    = occ + CNT_W'(push) - CNT_W'(pop);
        credit_next = CNT_W'(DEPTH) - occ_next;
        op_next     = is_put ? RSP_ACK : RSP_ACK_DATA;
    end

    wbuf_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (req_data),
        .pop   (pop),
        .rdata (cons_data),
        .occ   (occ),
        .full  (full),
        .empty (empty)
    );

    wbuf_rsp_slot #(.CNT_W(CNT_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .ld_op     (op_next),
        .ld_credit (credit_next),
        .drain     (rsp_ready),
        .valid     (rsp_valid),
        .op        (op_q),
        .credit    (rsp_credit),
        .slot_free (slot_free)
    );

    assign rsp_opcode = op_q;
    assign rsp_data   = '0;
    assign cons_valid = !empty;
endmodule

// File: rtl/credit_wbuf_chk.sv
// Protocol and credit checker, bound to credit_wbuf.
module credit_wbuf_chk #(
    parameter int DEPTH  = 16,
    parameter int MASK_W = 4,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_opcode,
    input logic [MASK_W-1:0] req_mask,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [2:0]        rsp_opcode,
    input logic [CNT_W-1:0]  rsp_credit,
    input logic              cons_en,
    input logic              cons_valid,
    input logic [CNT_W-1:0]  occ
);
    p_accept_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_query_no_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_opcode == 3'd1 && req_mask == '0
         && !(cons_en && cons_valid)) |=> occ == $past(occ));

    p_credit_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_credit == CNT_W'(DEPTH) - occ);

    p_read_ack_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_opcode > 3'd1) |=> rsp_opcode == 3'd1);

    p_stall_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH)) |-> !req_ready);

    p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
        (rsp_valid && $stable(rsp_opcode) && $stable(rsp_credit)));

    p_cons_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cons_valid == (occ != '0));
endmodule

bind credit_wbuf credit_wbuf_chk #(.DEPTH(DEPTH), .MASK_W(MASK_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_opcode (req_opcode),
    .req_mask   (req_mask),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_opcode (rsp_opcode),
    .rsp_credit (rsp_credit),
    .cons_en    (cons_en),
    .cons_valid (cons_valid),
    .occ        (occ)
);

// File: tb/credit_wbuf_test.sv
`timescale 1ns/1ps
// Bench: behavioural queue model compared with the design every cycle.
module credit_wbuf_test;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_opcode = 3'd0;
    logic [3:0]  req_mask = 4'd0;
    logic [31:0] req_data = 32'd0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [2:0]  rsp_opcode;
    logic [4:0]  rsp_credit;
    logic [31:0] rsp_data;
    logic        cons_en = 1'b0;
    logic        cons_valid;
    logic [31:0] cons_data;

    int    vecs = 0;
    int    fails = 0;
    string phase = "R1 reset";

    int q[$];
    bit m_rv = 0;
    int m_rop = 0;
    int m_rcred = 0;

    always #4 clk = ~clk;

    credit_wbuf uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
        .req_mask(req_mask), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_opcode(rsp_opcode),
        .rsp_credit(rsp_credit), .rsp_data(rsp_data),
        .cons_en(cons_en), .cons_valid(cons_valid), .cons_data(cons_data)
    );

    function automatic bit m_ready();
        return (!m_rv || rsp_ready) && (q.size() < DEPTH);
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        bit acc, pp, wr, ps;
        if (!rst_n) begin
            q.delete();
            m_rv = 0;
        end else begin
            acc = req_valid && m_ready();
            pp  = cons_en && (q.size() > 0);
            wr  = (req_opcode == 3'd0) || (req_opcode == 3'd1);
            ps  = acc && wr && ((req_opcode == 3'd0) || (req_mask != 4'd0));
            if (pp) void'(q.pop_front());
            if (ps) q.push_back(int'(req_data));
            if (acc) begin
                m_rv = 1;
                m_rop = wr ? 0 : 1;
                m_rcred = DEPTH - q.size();
            end else if (rsp_ready) begin
                m_rv = 0;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL [%s] %s: actual %0h expected %0h", phase, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("R6 R7 req_ready", 32'(req_ready), 32'(m_ready()));
        chk("R7 rsp_valid", 32'(rsp_valid), 32'(m_rv));
        if (m_rv) begin
            chk("R2 R3 R5 rsp_opcode", 32'(rsp_opcode), 32'(m_rop));
            chk("R4 rsp_credit", 32'(rsp_credit), 32'(m_rcred));
            chk("R5 rsp_data", rsp_data, 32'd0);
        end
        chk("R8 cons_valid", 32'(cons_valid), 32'(q.size() > 0));
        if (q.size() > 0) chk("R8 cons_data", cons_data, 32'(q[0]));
    endtask

    task automatic step(input bit v, input logic [2:0] op, input logic [3:0] m,
                        input logic [31:0] d, input bit rr, input bit ce);
        @(negedge clk);
        req_valid = v; req_opcode = op; req_mask = m; req_data = d;
        rsp_ready = rr; cons_en = ce;
        #1;
        compare();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state straight after reset
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 cons_valid", 32'(cons_valid), 32'd0);
        chk("R1 req_ready", 32'(req_ready), 32'd1);

        phase = "R2 full puts";
        for (int i = 0; i < 3; i++) step(1, 3'd0, 4'hF, 32'hA000_0000 + 32'(i), 1, 0);

        phase = "R3 zero-mask query";
        step(1, 3'd1, 4'h0, 32'hDEAD_BEEF, 1, 0);
        step(1, 3'd1, 4'h2, 32'hB000_0001, 1, 0);

        phase = "R5 read";
        step(1, 3'd4, 4'hF, 32'h0, 1, 0);
        step(0, 3'd0, 4'h0, 32'h0, 1, 0);

        phase = "R4 R6 fill and stall";
        for (int i = 0; i < 16; i++) step(1, 3'd0, 4'hF, 32'hC000_0000 + 32'(i), 1, 0);
        step(0, 3'd0, 4'h0, 32'h0, 1, 0);

        phase = "R8 drain";
        for (int i = 0; i < 5; i++) step(0, 3'd0, 4'h0, 32'h0, 1, 1);

        phase = "R7 back-pressure";
        for (int i = 0; i < 4; i++) step(1, 3'd4, 4'h0, 32'h0, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 3'd0, 4'hF, 32'hD000_0000 + 32'(i), 1, 0);

        phase = "R2 R3 R4 R8 mixed";
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op;
            op = ($urandom_range(0, 3) == 0) ? 3'd4 : 3'($urandom_range(0, 1));
            step($urandom_range(0, 3) != 0, op, 4'($urandom_range(0, 15)) & {4{$urandom_range(0, 2) != 0}},
                 $urandom(), $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule